// File: doc/BRIEF.md
# Shift and Invert Execution Unit

This unit carries out the single-source register-to-register instruction group of a 32-bit datapath. An issuing stage presents a five-bit opcode, the index of the source register, the value read from that register and the five-bit count field of the instruction word. The unit returns the computed word and a valid flag. Four shift flavours and a bitwise inversion are supported. Register file access and condition flags belong to neighbouring blocks.

Only left rotation exists in hardware. A small side helper turns a requested right rotation by N into the equivalent left-rotation count, so that an assembler or decoder can reuse the left-rotate opcode. Issued operations and the helper are independent and may be used in the same cycle.

The shifter is a shared log2-stage network. It is followed by an output register that a parameter can remove. The only stored state is that register pair, result and valid. Reset clears it, each clock loads it from the current inputs, and no other state or transition exists.

Top module: `xu_shift_unit`

## Requirements
- R1: Opcode 10000 shifts the operand left and fills with zeros. Opcode 10001 rotates it left. Opcode 10010 shifts it right and fills with zeros. In each case the amount is the count field, 0 to 31. The valid flag is set.
- R2: For any of the four shift opcodes, a count of zero returns the operand unchanged, which acts as a register move.
- R3: Opcode 10100 returns the bitwise inverse of the operand, and the value of the count field has no effect on the result.
- R4: When the source register index is zero, the operand is taken as zero. All four shifts then return zero, and inversion returns all ones.
- R5: Opcode 10011 shifts right and copies the operand's bit 31 into every vacated position. Opcode 10010 fills those positions with zeros.
- R6: Every other opcode returns a zero result with the valid flag low. This covers 10101 to 10111 as well as all codes outside the 10xxx group.
- R7: The rotate helper outputs (32 - N) mod 32 for a requested right rotation by N, so N = 0 maps to 0.
- R8: With the default registered output, the result and valid flag appear one clock after issue. When issue is low, valid is low and the result is zero. Reset clears both outputs.
- R9: A left shift (10000) by one returns twice the operand, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| src_idx_i | input | 5 | Source register index (0 forces a zero operand) |
| src_val_i | input | 32 | Source register value |
| cnt_i | input | 5 | Count field |
| rrot_n_i | input | 5 | Requested right-rotation amount for the helper |
| rrot_cnt_o | output | 5 | Equivalent left-rotation count |
| res_o | output | 32 | Result word |
| res_valid_o | output | 1 | Result is from a recognised operation |

## Verification
Two functions that meet on one instruction are the zero-index clear and the zero-count move. The bench provokes this by issuing every shift opcode and the inversion with source index zero and count zero, and it also issues them with index zero and non-zero counts. The clear must win: the four shifts return zero and the inversion returns all ones, never the raw source value. In the same cycles the rotate helper is driven with fresh amounts, and its output is judged against the modulo rule alongside the issued result.

// File: rtl/xu_shift_pkg.sv
package xu_shift_pkg;

    typedef enum logic [4:0] {
        OP_SHL = 5'b10000,
        OP_ROL = 5'b10001,
        OP_SHR = 5'b10010,
        OP_SAR = 5'b10011,
        OP_INV = 5'b10100
    } xu_op_e;

    typedef enum logic [1:0] {
        MODE_SHL,
        MODE_ROL,
        MODE_SHR,
        MODE_SAR
    } xu_mode_e;

    function automatic logic op_is_shift(input logic [4:0] op);
        return (op == OP_SHL) || (op == OP_ROL) || (op == OP_SHR) || (op == OP_SAR);
    endfunction

    function automatic logic op_is_known(input logic [4:0] op);
        return op_is_shift(op) || (op == OP_INV);
    endfunction

endpackage

// File: rtl/xu_barrel.sv
module xu_barrel
    import xu_shift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xu_mode_e                    mode_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic [$clog2(DATA_W)-1:0]   cnt_i,
    output logic [DATA_W-1:0]           data_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] stage [0:CNT_W];

    assign stage[0] = data_i;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [DATA_W-1:0] moved;

        always_comb begin
            case (mode_i)
                MODE_SHL: moved = {stage[k][DATA_W-1-D:0], {D{1'b0}}};
                MODE_ROL: moved = {stage[k][DATA_W-1-D:0], stage[k][DATA_W-1:DATA_W-D]};
                MODE_SHR: moved = {{D{1'b0}}, stage[k][DATA_W-1:D]};
                MODE_SAR: moved = {{D{stage[k][DATA_W-1]}}, stage[k][DATA_W-1:D]};
                default:  moved = stage[k];
            endcase
        end

        assign stage[k+1] = cnt_i[k] ? moved : stage[k];
    end

    assign data_o = stage[CNT_W];

endmodule

// File: rtl/xu_rrot_map.sv
module xu_rrot_map #(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W)-1:0] n_i,
    output logic [$clog2(DATA_W)-1:0] left_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W:0] diff;

    always_comb begin
        diff = (CNT_W+1)'(DATA_W) - {1'b0, n_i};
        left_o = diff[CNT_W-1:0];
    end

endmodule

// File: rtl/xu_out_stage.sv
module xu_out_stage #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_d,
    input  logic              vld_d,
    output logic [DATA_W-1:0] res_q,
    output logic              vld_q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                res_q <= res_d;
                vld_q <= vld_d;
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
        assign vld_q = vld_d;
    end

endmodule

// File: rtl/xu_shift_unit.sv
module xu_shift_unit
    import xu_shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        issue_i,
    input  logic [4:0]                  op_i,
    input  logic [REG_IDX_W-1:0]        src_idx_i,
    input  logic [DATA_W-1:0]           src_val_i,
    input  logic [$clog2(DATA_W)-1:0]   cnt_i,
    input  logic [$clog2(DATA_W)-1:0]   rrot_n_i,
    output logic [$clog2(DATA_W)-1:0]   rrot_cnt_o,
    output logic [DATA_W-1:0]           res_o,
    output logic                        res_valid_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] res_d;
    logic              vld_d;
    xu_mode_e          mode;

    // R4: register zero reads as a zero operand
    assign operand = (src_idx_i == '0) ? '0 : src_val_i;

    always_comb begin
        case (op_i)
            OP_ROL:  mode = MODE_ROL;
            OP_SHR:  mode = MODE_SHR;
            OP_SAR:  mode = MODE_SAR;
            default: mode = MODE_SHL;
        endcase
    end

    xu_barrel #(.DATA_W(DATA_W)) u_barrel (
        .mode_i (mode),
        .data_i (operand),
        .cnt_i  (cnt_i),
        .data_o (shifted)
    );

    // R3, R6: inversion ignores the count; unknown codes give zero and no valid
    always_comb begin
        res_d = '0;
        vld_d = 1'b0;
        if (issue_i) begin
            if (op_is_shift(op_i)) begin
                res_d = shifted;
                vld_d = 1'b1;
            end else if (op_i == OP_INV) begin
                res_d = ~operand;
                vld_d = 1'b1;
            end
        end
    end

    xu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .res_d (res_d),
        .vld_d (vld_d),
        .res_q (res_o),
        .vld_q (res_valid_o)
    );

    // R7: right-rotation helper
    xu_rrot_map #(.DATA_W(DATA_W)) u_rrot (
        .n_i    (rrot_n_i),
        .left_o (rrot_cnt_o)
    );

    logic [CNT_W-1:0] unused_cnt_w;
    assign unused_cnt_w = '0;

endmodule

// File: rtl/xu_shift_unit_chk.sv
module xu_shift_unit_chk
    import xu_shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter bit REG_OUT   = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        issue_i,
    input logic [4:0]                  op_i,
    input logic [REG_IDX_W-1:0]        src_idx_i,
    input logic [DATA_W-1:0]           src_val_i,
    input logic [$clog2(DATA_W)-1:0]   cnt_i,
    input logic [$clog2(DATA_W)-1:0]   rrot_n_i,
    input logic [$clog2(DATA_W)-1:0]   rrot_cnt_o,
    input logic [DATA_W-1:0]           res_o,
    input logic                        res_valid_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic                 d_issue;
    logic [4:0]           d_op;
    logic [REG_IDX_W-1:0] d_idx;
    logic [DATA_W-1:0]    d_val;
    logic [CNT_W-1:0]     d_cnt;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_issue <= 1'b0;
                d_op    <= '0;
                d_idx   <= '0;
                d_val   <= '0;
                d_cnt   <= '0;
            end else begin
                d_issue <= issue_i;
                d_op    <= op_i;
                d_idx   <= src_idx_i;
                d_val   <= src_val_i;
                d_cnt   <= cnt_i;
            end
        end
    end else begin : g_nodly
        assign d_issue = issue_i;
        assign d_op    = op_i;
        assign d_idx   = src_idx_i;
        assign d_val   = src_val_i;
        assign d_cnt   = cnt_i;
    end

    logic [CNT_W-1:0] rot_sum;
    assign rot_sum = rrot_cnt_o + rrot_n_i;

    a_r2_zero_count_move: assert property (@(posedge clk) disable iff (!rst_n)
        (d_issue && op_is_shift(d_op) && d_cnt == '0 && d_idx != '0)
        |-> (res_valid_o && res_o == d_val));

    a_r3_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (d_issue && d_op == OP_INV && d_idx != '0) |-> (res_valid_o && res_o == ~d_val));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (d_issue && op_is_shift(d_op) && d_idx == '0) |-> (res_o == '0));

    a_r1_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (d_issue && d_op == OP_ROL && d_idx != '0)
        |-> ($countones(res_o) == $countones(d_val)));

    a_r6_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (d_issue && !op_is_known(d_op)) |-> (!res_valid_o && res_o == '0));

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_issue) |-> (!res_valid_o && res_o == '0));

    a_r7_rrot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rrot_n_i == '0) |-> (rrot_cnt_o == '0));

    a_r7_rrot_sum: assert property (@(posedge clk) disable iff (!rst_n)
        rot_sum == '0);

endmodule

bind xu_shift_unit xu_shift_unit_chk #(
    .DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .src_idx_i(src_idx_i), .src_val_i(src_val_i), .cnt_i(cnt_i),
    .rrot_n_i(rrot_n_i), .rrot_cnt_o(rrot_cnt_o),
    .res_o(res_o), .res_valid_o(res_valid_o)
);

// File: tb/xu_shift_unit_tb.sv
module xu_shift_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [4:0]  src_idx_i = '0;
    logic [31:0] src_val_i = '0;
    logic [4:0]  cnt_i = '0;
    logic [4:0]  rrot_n_i = '0;
    logic [4:0]  rrot_cnt_o;
    logic [31:0] res_o;
    logic        res_valid_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xu_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .src_idx_i(src_idx_i), .src_val_i(src_val_i), .cnt_i(cnt_i),
        .rrot_n_i(rrot_n_i), .rrot_cnt_o(rrot_cnt_o),
        .res_o(res_o), .res_valid_o(res_valid_o)
    );

    // Behavioural reference: {valid, result}
    function automatic logic [32:0] ref_eval(input logic iss, input logic [4:0] op,
                                             input logic [4:0] idx, input logic [31:0] v,
                                             input logic [4:0] c);
        logic [31:0] a;
        logic [63:0] dbl;
        a = (idx == 0) ? 32'd0 : v;
        if (!iss) return 33'd0;
        case (op)
            5'b10000: return {1'b1, a << c};
            5'b10001: begin dbl = {a, a} << c; return {1'b1, dbl[63:32]}; end
            5'b10010: return {1'b1, a >> c};
            5'b10011: return {1'b1, 32'($signed(a) >>> c)};
            5'b10100: return {1'b1, ~a};
            default:  return 33'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic iss, input logic [4:0] op,
                                     input logic [4:0] idx, input logic [4:0] c);
        if (!iss) return "R8";
        if (op < 5'b10000 || op > 5'b10100) return "R6";
        if (idx == 0) return "R4";
        if (op == 5'b10100) return "R3";
        if (c == 0) return "R2";
        if (op == 5'b10010 || op == 5'b10011) return "R5";
        if (op == 5'b10000 && c == 1) return "R9";
        return "R1";
    endfunction

    logic [32:0] exp_q;
    string       tag_q;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= 33'd0;
            tag_q <= "R8";
        end else begin
            exp_q <= ref_eval(issue_i, op_i, src_idx_i, src_val_i, cnt_i);
            tag_q <= tag_of(issue_i, op_i, src_idx_i, cnt_i);
        end
    end

    // Compare every clock, half a period after the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [4:0] exp_rot;
            n_chk++;
            if ({res_valid_o, res_o} !== exp_q) begin
                n_err++;
                $display("FAIL %s: result actual=%0b/%08h expected=%0b/%08h",
                         tag_q, res_valid_o, res_o, exp_q[32], exp_q[31:0]);
            end
            exp_rot = 5'((32 - int'(rrot_n_i)) % 32);
            n_chk++;
            if (rrot_cnt_o !== exp_rot) begin
                n_err++;
                $display("FAIL R7: rotate map n=%0d actual=%0d expected=%0d",
                         rrot_n_i, rrot_cnt_o, exp_rot);
            end
        end
    end

    task automatic drive(input logic iss, input logic [4:0] op, input logic [4:0] idx,
                         input logic [31:0] v, input logic [4:0] c, input logic [4:0] rn);
        @(posedge clk);
        #3;
        issue_i = iss; op_i = op; src_idx_i = idx; src_val_i = v; cnt_i = c; rrot_n_i = rn;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R1 main shifts
        drive(1, 5'b10000, 5'd3, 32'h0000_0001, 5'd31, 5'd0);
        drive(1, 5'b10001, 5'd3, 32'h8000_0001, 5'd1,  5'd1);
        drive(1, 5'b10001, 5'd3, 32'h1234_5678, 5'd31, 5'd31);
        drive(1, 5'b10010, 5'd3, 32'h8000_0000, 5'd31, 5'd16);
        // R5 fill behaviour
        drive(1, 5'b10011, 5'd3, 32'h8000_0000, 5'd31, 5'd3);
        drive(1, 5'b10011, 5'd3, 32'h7FFF_0000, 5'd4,  5'd29);
        drive(1, 5'b10010, 5'd3, 32'hF000_000F, 5'd4,  5'd2);
        // R9 doubling
        drive(1, 5'b10000, 5'd3, 32'h4000_0001, 5'd1,  5'd0);
        // R2 zero count moves
        for (int o = 16; o < 20; o++) drive(1, 5'(o), 5'd7, 32'hDEAD_BEEF, 5'd0, 5'(o));
        // R3 inversion with varied counts
        drive(1, 5'b10100, 5'd2, 32'h0F0F_00FF, 5'd17, 5'd5);
        drive(1, 5'b10100, 5'd2, 32'h0F0F_00FF, 5'd0,  5'd6);
        // R4 clear meets zero count and non-zero count
        for (int o = 16; o < 21; o++) drive(1, 5'(o), 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd8);
        for (int o = 16; o < 21; o++) drive(1, 5'(o), 5'd0, 32'hA5A5_A5A5, 5'd9, 5'd9);
        // R6 unknown codes
        drive(1, 5'b10101, 5'd1, 32'h1111_1111, 5'd2, 5'd10);
        drive(1, 5'b10111, 5'd1, 32'h1111_1111, 5'd2, 5'd11);
        drive(1, 5'b00000, 5'd1, 32'h1111_1111, 5'd2, 5'd12);
        drive(1, 5'b11111, 5'd1, 32'h1111_1111, 5'd2, 5'd13);
        // R8 no issue
        drive(0, 5'b10100, 5'd1, 32'h1111_1111, 5'd2, 5'd14);
        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [4:0] op;
            op = ($urandom % 4 == 0) ? 5'($urandom) : 5'(5'b10000 + ($urandom % 6));
            drive(($urandom % 8) != 0, op, 5'($urandom % 6), $urandom, 5'($urandom), 5'($urandom));
        end
        drive(0, 5'd0, 5'd0, 32'd0, 5'd0, 5'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R8: watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule